// File: doc/BRIEF.md
# Shared Single-Word Mailbox Bank with Level Interrupts

This block holds a small bank of single-word mailboxes through which a producer and a consumer pass one 31-bit message at a time. Each mailbox word carries its message in the low 31 bits and an occupancy flag in the top bit. One write therefore both stores a message and marks the mailbox occupied. The consumer drains the mailbox by writing zero to the whole word.

Every mailbox drives two level conditions. The occupied condition holds while the flag is set, and the vacant condition holds while it is clear. Each condition passes through a local per-mailbox enable. The results are gathered into one status word, with vacant conditions in the low byte and occupied conditions in the next byte, and the bit position equal to the mailbox index. A global mask with the same layout gates the status onto a single interrupt line.

Access goes through a plain register bus with no back-pressure. A request is accepted in the cycle it is presented. A read answers with a one-cycle response pulse in the next cycle, and that response cannot be stalled. A read-only sizing register reports the mailbox count and further fixed count fields.

Top module: `shared_mbox`

Address map: global registers sit at slot 0 (status at 0x00, mask at 0x04, sizing at 0x08). Mailbox i sits at base 0x10*(i+1), with the word at +0x0, the occupied enable at +0x4 and the vacant enable at +0x8.

## Requirements
- R1: A write to a mailbox word stores bits [30:0] as the message and bit 31 as the occupied flag. A read of that word returns {flag, message}.
- R2: A write of zero to a mailbox word clears both the message and the flag. Any write with bit 31 clear leaves the mailbox vacant and holding the written message bits.
- R3: A write with bit 31 set to an already occupied mailbox replaces the message, and the mailbox stays occupied. No error is reported.
- R4: Status bit i (i < mailbox count) is 1 exactly when mailbox i is vacant and its vacant enable is set. Status bit 8+i is 1 exactly when mailbox i is occupied and its occupied enable is set. All other status bits read 0.
- R5: The status register is read-only. Writes to it change neither its value nor any other register.
- R6: The interrupt output is 1 exactly when some status bit and the same global mask bit are both 1. The mask uses the status layout, and only bits [i] and [8+i] for implemented mailboxes are writable; the rest read 0.
- R7: The occupied enable (+0x4) and the vacant enable (+0x8) of each mailbox use bit 0 only. The other bits read 0.
- R8: The sizing register at 0x08 reads {12'b0, OTHER_COUNTS[15:0], mailbox count[3:0]}. Writes to it are ignored.
- R9: After reset all mailboxes are vacant and hold zero, all enables and the mask are 0, the status reads 0 and the interrupt is low.
- R10: A read request produces rsp_vld high for exactly one cycle, in the next cycle, with the data. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Bus request present; always accepted |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Read response pulse, one cycle after a read |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Shared level interrupt |

## Verification
The assertions assume that at most one request arrives per cycle. They also assume that no request is presented while reset is asserted, because the status-stability and response-pulse properties relate every change to a request issued in the previous cycle. The bench drives each request for exactly one cycle on the falling edge and keeps req_vld low throughout reset. It never overlaps two requests and samples responses and the interrupt on the following falling edge.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned SLOT_LG = 4;
  localparam logic [3:0] G_STAT   = 4'h0;
  localparam logic [3:0] G_MASK   = 4'h4;
  localparam logic [3:0] G_DIM    = 4'h8;
  localparam logic [3:0] OFF_WORD = 4'h0;
  localparam logic [3:0] OFF_FEN  = 4'h4;
  localparam logic [3:0] OFF_EEN  = 4'h8;

  typedef struct packed {
    logic        occ;
    logic [30:0] msg;
  } mbox_word_t;
endpackage

// File: rtl/smb_slot.sv
module smb_slot
  import smb_pkg::*;
#(
  parameter bit LOCAL_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we_word,
  input  logic        we_fen,
  input  logic        we_een,
  input  logic [31:0] wdata,
  output mbox_word_t  word,
  output logic        fen,
  output logic        een,
  output logic        st_vacant,
  output logic        st_occ
);
  mbox_word_t word_q;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (we_word) word_q <= wdata;
  end

  generate
    if (LOCAL_EN) begin : g_local
      logic fen_q, een_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          fen_q <= 1'b0;
          een_q <= 1'b0;
        end else begin
          if (we_fen) fen_q <= wdata[0];
          if (we_een) een_q <= wdata[0];
        end
      end
      assign fen = fen_q;
      assign een = een_q;
    end else begin : g_fixed
      assign fen = 1'b1;
      assign een = 1'b1;
    end
  endgenerate

  assign word      = word_q;
  assign st_vacant = !word_q.occ && een;
  assign st_occ    = word_q.occ && fen;
endmodule

// File: rtl/smb_irq.sv
module smb_irq #(
  parameter int unsigned NUM_MB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic [31:0]       wdata,
  input  logic [NUM_MB-1:0] st_vacant,
  input  logic [NUM_MB-1:0] st_occ,
  output logic [31:0]       status,
  output logic [31:0]       mask,
  output logic              irq
);
  localparam logic [7:0]  IMPL     = 8'((9'd1 << NUM_MB) - 9'd1);
  localparam logic [31:0] MASK_WRB = {16'b0, IMPL, IMPL};

  logic [7:0]  vac_f, occ_f;
  logic [31:0] mask_q;

  always_comb begin
    vac_f = '0;
    occ_f = '0;
    vac_f[NUM_MB-1:0] = st_vacant;
    occ_f[NUM_MB-1:0] = st_occ;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= wdata & MASK_WRB;
  end

  assign status = {16'b0, occ_f, vac_f};
  assign mask   = mask_q;
  assign irq    = |(status & mask_q);
endmodule

// File: rtl/shared_mbox.sv
module shared_mbox
  import smb_pkg::*;
#(
  parameter int unsigned NUM_MB       = 4,
  parameter int unsigned ADDR_W       = 8,
  parameter bit          LOCAL_EN     = 1'b1,
  parameter logic [15:0] OTHER_COUNTS = 16'h0120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_vld,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);
  localparam int unsigned SEL_W   = ADDR_W - SLOT_LG;
  localparam logic [31:0] DIM_VAL = {12'b0, OTHER_COUNTS, 4'(NUM_MB)};

  logic [SEL_W-1:0] sel;
  logic [3:0]       off;
  logic             wr_go, rd_go;
  logic             mask_we;

  mbox_word_t        words [NUM_MB];
  logic [NUM_MB-1:0] fen_v, een_v, vac_v, occ_v;
  logic [31:0]       stat_w, mask_w;
  logic [31:0]       rd_val;
  logic              rsp_vld_q;
  logic [31:0]       rsp_rdata_q;

  assign sel     = req_addr[ADDR_W-1:SLOT_LG];
  assign off     = req_addr[SLOT_LG-1:0];
  assign wr_go   = req_vld && req_wr;
  assign rd_go   = req_vld && !req_wr;
  assign mask_we = wr_go && (sel == '0) && (off == G_MASK);

  generate
    for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
      logic hit;
      assign hit = (sel == SEL_W'(i + 1));
      smb_slot #(.LOCAL_EN(LOCAL_EN)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .we_word  (wr_go && hit && (off == OFF_WORD)),
        .we_fen   (wr_go && hit && (off == OFF_FEN)),
        .we_een   (wr_go && hit && (off == OFF_EEN)),
        .wdata    (req_wdata),
        .word     (words[i]),
        .fen      (fen_v[i]),
        .een      (een_v[i]),
        .st_vacant(vac_v[i]),
        .st_occ   (occ_v[i])
      );
    end
  endgenerate

  smb_irq #(.NUM_MB(NUM_MB)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .mask_we  (mask_we),
    .wdata    (req_wdata),
    .st_vacant(vac_v),
    .st_occ   (occ_v),
    .status   (stat_w),
    .mask     (mask_w),
    .irq      (irq)
  );

  always_comb begin
    rd_val = '0;
    if (sel == '0) begin
      case (off)
        G_STAT:  rd_val = stat_w;
        G_MASK:  rd_val = mask_w;
        G_DIM:   rd_val = DIM_VAL;
        default: rd_val = '0;
      endcase
    end
    for (int i = 0; i < NUM_MB; i++) begin
      if (sel == SEL_W'(i + 1)) begin
        case (off)
          OFF_WORD: rd_val = words[i];
          OFF_FEN:  rd_val = {31'b0, fen_v[i]};
          OFF_EEN:  rd_val = {31'b0, een_v[i]};
          default:  rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_vld_q <= rd_go;
      if (rd_go) rsp_rdata_q <= rd_val;
    end
  end

  assign rsp_vld   = rsp_vld_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/smb_chk.sv
module smb_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_vld,
  input logic        req_wr,
  input logic        rsp_vld,
  input logic        irq,
  input logic [31:0] stat
);
  // R10
  rd_gets_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_wr) |=> rsp_vld);

  // R10
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> $past(req_vld && !req_wr));

  // R9
  clean_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && stat == 32'b0));

  // R4
  vac_occ_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[7:0] & stat[15:8]) == 8'b0);

  // R5
  stat_moves_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_vld && req_wr) |=> $stable(stat));

  // R4
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat[31:16] == 16'b0);
endmodule

bind shared_mbox smb_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .req_vld(req_vld),
  .req_wr (req_wr),
  .rsp_vld(rsp_vld),
  .irq    (irq),
  .stat   (stat_w)
);

// File: tb/shared_mbox_bench.sv
module shared_mbox_bench;
  localparam int unsigned NMB = 4;
  localparam logic [15:0] OC  = 16'h0120;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic        req_wr = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_vld;
  logic [31:0] rsp_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_word [NMB];
  bit          m_fen  [NMB];
  bit          m_een  [NMB];
  logic [31:0] m_mask;

  always #10 clk = ~clk;

  shared_mbox #(.NUM_MB(NMB), .ADDR_W(8), .LOCAL_EN(1'b1), .OTHER_COUNTS(OC)) u_shared_mbox (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  function automatic logic [7:0] mb(int i, int off);
    return 8'(16 * (i + 1) + off);
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    for (int i = 0; i < NMB; i++) begin
      if (!m_word[i][31] && m_een[i]) s[i] = 1'b1;
      if (m_word[i][31] && m_fen[i])  s[8 + i] = 1'b1;
    end
    return s;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, input string req);
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b0; req_addr = a;
    @(negedge clk);
    req_vld = 1'b0;
    chk(rsp_vld === 1'b1, req, {31'b0, rsp_vld}, 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    chk(rsp_vld === 1'b0, req, {31'b0, rsp_vld}, 32'd0);
  endtask

  task automatic chk_stat_irq(string req);
    logic [31:0] v;
    logic [31:0] es;
    es = exp_stat();
    rd(8'h00, v, req);
    chk(v === es, req, v, es);
    chk(irq === |(es & m_mask), "R6", {31'b0, irq}, {31'b0, |(es & m_mask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NMB; i++) begin
      m_word[i] = '0; m_fen[i] = 0; m_een[i] = 0;
    end
    m_mask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk(irq === 1'b0, "R9", {31'b0, irq}, 32'd0);
    rd(8'h00, v, "R9"); chk(v === 32'd0, "R9", v, 32'd0);
    rd(8'h04, v, "R9"); chk(v === 32'd0, "R9", v, 32'd0);
    for (int i = 0; i < NMB; i++) begin
      rd(mb(i, 0), v, "R9"); chk(v === 32'd0, "R9", v, 32'd0);
      rd(mb(i, 4), v, "R9"); chk(v === 32'd0, "R9", v, 32'd0);
      rd(mb(i, 8), v, "R9"); chk(v === 32'd0, "R9", v, 32'd0);
    end

    // R8 sizing register and write ignored
    rd(8'h08, v, "R8"); chk(v === {12'b0, OC, 4'(NMB)}, "R8", v, {12'b0, OC, 4'(NMB)});
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v, "R8"); chk(v === {12'b0, OC, 4'(NMB)}, "R8", v, {12'b0, OC, 4'(NMB)});

    // R10 unmapped reads
    rd(8'h0C, v, "R10"); chk(v === 32'd0, "R10", v, 32'd0);
    rd(8'hF0, v, "R10"); chk(v === 32'd0, "R10", v, 32'd0);

    // R6 mask writable bits
    wr(8'h04, 32'hFFFF_FFFF);
    m_mask = 32'h0000_0F0F;
    rd(8'h04, v, "R6"); chk(v === m_mask, "R6", v, m_mask);
    chk(irq === 1'b0, "R6", {31'b0, irq}, 32'd0);

    // R7 local enables use bit 0 only
    wr(mb(1, 4), 32'hFFFF_FFFE);
    rd(mb(1, 4), v, "R7"); chk(v === 32'd0, "R7", v, 32'd0);
    wr(mb(1, 8), 32'hFFFF_FFFF); m_een[1] = 1;
    rd(mb(1, 8), v, "R7"); chk(v === 32'd1, "R7", v, 32'd1);
    chk_stat_irq("R4");

    // sweep: every mailbox, every enable pair, both occupancy states, shifting masks
    for (int i = 0; i < NMB; i++) begin
      logic [31:0] mv;
      mv = 32'hFFFF_FFFF ^ (32'h0000_0101 << i);
      wr(8'h04, mv);
      m_mask = mv & 32'h0000_0F0F;
      for (int e = 0; e < 4; e++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] d;
          wr(mb(i, 4), 32'(e & 1)); m_fen[i] = bit'(e & 1);
          wr(mb(i, 8), 32'(e >> 1)); m_een[i] = bit'(e >> 1);
          d = (s == 1) ? ({1'b1, 31'(32'h1357_9BDF * (i + 1) + e)}) : 32'd0;
          wr(mb(i, 0), d); m_word[i] = d;
          rd(mb(i, 0), v, (s == 1) ? "R1" : "R2");
          chk(v === d, (s == 1) ? "R1" : "R2", v, d);
          chk_stat_irq("R4");
        end
      end
      wr(mb(i, 0), 32'h8000_0000 | 32'(i)); m_word[i] = 32'h8000_0000 | 32'(i);
    end

    // full mask with everything occupied and enabled
    wr(8'h04, 32'h0000_FFFF); m_mask = 32'h0000_0F0F;
    for (int i = 0; i < NMB; i++) begin
      wr(mb(i, 4), 32'd1); m_fen[i] = 1;
    end
    chk_stat_irq("R4");

    // R3 overwrite while occupied
    wr(mb(2, 0), 32'hDEAD_BEEF); m_word[2] = 32'hDEAD_BEEF;
    chk(irq === 1'b1, "R3", {31'b0, irq}, 32'd1);
    rd(mb(2, 0), v, "R3"); chk(v === 32'hDEAD_BEEF, "R3", v, 32'hDEAD_BEEF);
    chk_stat_irq("R3");

    // R2 write with flag clear but nonzero message
    wr(mb(3, 0), 32'h1234_5678); m_word[3] = 32'h1234_5678;
    rd(mb(3, 0), v, "R2"); chk(v === 32'h1234_5678, "R2", v, 32'h1234_5678);
    chk_stat_irq("R2");

    // R5 status write ignored
    wr(8'h00, 32'hFFFF_FFFF);
    chk_stat_irq("R5");
    rd(8'h04, v, "R5"); chk(v === m_mask, "R5", v, m_mask);
    wr(8'h00, 32'h0000_0000);
    chk_stat_irq("R5");

    // R6 mask cleared drops interrupt
    wr(8'h04, 32'd0); m_mask = '0;
    chk(irq === 1'b0, "R6", {31'b0, irq}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule